// File: doc/BRIEF.md
# Group Completion Table for a Two-Thread Core

This block tracks in-flight instructions for a core that runs two hardware threads at once. Instructions are not tracked one by one. Each dispatch group of up to five instructions from one thread takes a single table entry, and the table holds twenty entries shared by both threads. Each entry records the group's thread, which of its five slots hold real instructions, and which of those have finished executing.

Each entry runs a small state machine with three states. `ENT_FREE` means unused. `ENT_PEND` means allocated, with some valid slots still outstanding. `ENT_DONE` means every valid slot has finished and the group is waiting to retire. The transitions are:
- *allocate*: FREE to PEND, on an accepted dispatch.
- *finish*: PEND to DONE, when the last valid slot reports completion.
- *flush*: PEND or DONE to FREE, when the entry's thread is flushed.
- *retire*: DONE to FREE, when the entry is picked for commit.

Only the oldest group of a thread may retire, so retirement is in program order within each thread. At most one group retires per cycle. When the heads of both threads are ready, the older one goes first. A per-thread count of occupied entries is exported for fetch arbitration.

Top module: `gct_table`

## Requirements
- R1: After reset no entry is occupied: both occupancy counts are 0, `disp_stall` is low and `commit_valid` is low.
- R2: An accepted dispatch takes the lowest-numbered free entry. `disp_tag` shows that index in the same cycle, and from the next cycle the dispatching thread's occupancy is one higher.
- R3: A dispatch whose five-bit slot mask is all zero is ignored. No entry is taken and no occupancy changes.
- R4: `disp_stall` is high exactly when all entries are occupied. A dispatch offered while it is high is ignored.
- R5: A completion (entry tag, slot index 0..4 where bit i of the mask is slot i) marks that slot finished. Completions to a slot outside the group's mask, to a free entry, or repeated for a finished slot change nothing. The group becomes ready to retire one cycle after its last valid slot completes.
- R6: A ready group that is not the oldest occupied group of its thread does not retire.
- R7: When the oldest groups of both threads are ready, the one dispatched earlier retires first. At most one group retires per cycle.
- R8: While `commit_valid` is high, `commit_tag`, `commit_tid` and `commit_mask` give the retiring entry, its thread and its slot mask. The entry is free from the next cycle.
- R9: A flush of thread t frees every entry of thread t in one cycle and leaves the other thread's entries untouched. In that same cycle, a dispatch from thread t is dropped and no group of thread t is retired.
- R10: `occupancy` holds one count per thread, with thread t in bits [t*5 +: 5]. Each count includes both pending and ready entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch group offered this cycle |
| disp_tid | input | 1 | Thread of the offered group |
| disp_mask | input | 5 | Valid slots of the offered group |
| disp_stall | output | 1 | Table full; dispatch refused |
| disp_tag | output | 5 | Entry the group is written to |
| comp_valid | input | 1 | A slot finished executing |
| comp_tag | input | 5 | Entry of the finished slot |
| comp_slot | input | 3 | Slot index of the finished instruction |
| flush_valid | input | 1 | Flush request |
| flush_tid | input | 1 | Thread to flush |
| commit_valid | output | 1 | A group retires this cycle |
| commit_tag | output | 5 | Entry retiring |
| commit_tid | output | 1 | Thread of the retiring group |
| commit_mask | output | 5 | Slot mask of the retiring group |
| occupancy | output | 10 | Per-thread occupied-entry counts |

## Verification
The checker makes three assumptions about the inputs. Completions only name real slots of entries that are live. A flush and a dispatch for the other thread can share a cycle. `disp_tid` and `flush_tid` name one of the two threads. Its counting properties exclude cycles where a retire, flush or dispatch for the same thread overlaps the event being checked. The stimulus follows these assumptions everywhere except in three deliberate misuse cases, which the bench observes only through the occupancy and commit ports: completions to a slot outside the mask, to a free entry, and repeated for a finished slot. The fill-and-drain sweep uses every entry. It finishes groups youngest first, so that ready groups pile up behind unready thread heads.

// File: rtl/gct_pkg.sv
package gct_pkg;
    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,
        ENT_PEND = 2'd1,
        ENT_DONE = 2'd2
    } ent_state_e;
endpackage

// File: rtl/gct_free_pick.sv
module gct_free_pick #(
    parameter int N = 20
) (
    input  logic [N-1:0]         free_vec,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/gct_age_matrix.sv
module gct_age_matrix #(
    parameter int N = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_en,
    input  logic [$clog2(N)-1:0] alloc_idx,
    input  logic [N-1:0]         live,
    output logic [N-1:0][N-1:0]  older
);
    // older[r][c] = 1 : entry r was dispatched before entry c
    for (genvar r = 0; r < N; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                older[r] <= '0;
            end else if (alloc_en) begin
                if (int'(alloc_idx) == r) begin
                    older[r] <= '0;
                end else begin
                    older[r][alloc_idx] <= live[r];
                end
            end
        end
    end
endmodule

// File: rtl/gct_oldest.sv
module gct_oldest #(
    parameter int N = 20
) (
    input  logic [N-1:0][N-1:0] older,
    input  logic [N-1:0]        cand,
    output logic [N-1:0]        pick
);
    always_comb begin
        for (int i = 0; i < N; i++) begin
            pick[i] = cand[i];
            for (int j = 0; j < N; j++) begin
                if (cand[j] && older[j][i]) pick[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/gct_table.sv
module gct_table
    import gct_pkg::*;
#(
    parameter int ENTRIES = 20,
    parameter int SLOTS   = 5,
    parameter int THREADS = 2,
    localparam int TAG_W  = $clog2(ENTRIES),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       disp_valid,
    input  logic [TID_W-1:0]           disp_tid,
    input  logic [SLOTS-1:0]           disp_mask,
    output logic                       disp_stall,
    output logic [TAG_W-1:0]           disp_tag,
    input  logic                       comp_valid,
    input  logic [TAG_W-1:0]           comp_tag,
    input  logic [SLOT_W-1:0]          comp_slot,
    input  logic                       flush_valid,
    input  logic [TID_W-1:0]           flush_tid,
    output logic                       commit_valid,
    output logic [TAG_W-1:0]           commit_tag,
    output logic [TID_W-1:0]           commit_tid,
    output logic [SLOTS-1:0]           commit_mask,
    output logic [THREADS*CNT_W-1:0]   occupancy
);
    logic [ENTRIES-1:0]              live;
    logic [ENTRIES-1:0]              ready;
    logic [ENTRIES-1:0][TID_W-1:0]   tid_all;
    logic [ENTRIES-1:0][SLOTS-1:0]   vm_all;
    logic [ENTRIES-1:0][ENTRIES-1:0] older;
    logic [ENTRIES-1:0]              alloc_oh;
    logic [ENTRIES-1:0]              kill;
    logic [ENTRIES-1:0]              head_any;
    logic [ENTRIES-1:0]              eligible;
    logic [ENTRIES-1:0]              commit_oh;
    logic [ENTRIES-1:0]              thr_mask [THREADS];
    logic [ENTRIES-1:0]              head     [THREADS];
    logic                            have_free;
    logic [TAG_W-1:0]                free_idx;
    logic                            disp_go;

    // ---------------- allocation ----------------
    gct_free_pick #(.N(ENTRIES)) u_free (
        .free_vec (~live),
        .found    (have_free),
        .idx      (free_idx)
    );

    assign disp_stall = ~have_free;
    assign disp_tag   = free_idx;
    assign disp_go    = disp_valid && (|disp_mask) && have_free &&
                        !(flush_valid && flush_tid == disp_tid);
    assign alloc_oh   = disp_go ? (ENTRIES'(1) << free_idx) : '0;

    gct_age_matrix #(.N(ENTRIES)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (disp_go),
        .alloc_idx (free_idx),
        .live      (live),
        .older     (older)
    );

    // ---------------- per-thread heads and occupancy ----------------
    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        logic [CNT_W-1:0] cnt;
        always_comb begin
            for (int i = 0; i < ENTRIES; i++) begin
                thr_mask[t][i] = live[i] && (tid_all[i] == TID_W'(t));
            end
        end
        gct_oldest #(.N(ENTRIES)) u_head (
            .older (older),
            .cand  (thr_mask[t]),
            .pick  (head[t])
        );
        always_comb begin
            cnt = '0;
            for (int i = 0; i < ENTRIES; i++) begin
                cnt = cnt + CNT_W'(thr_mask[t][i]);
            end
        end
        assign occupancy[t*CNT_W +: CNT_W] = cnt;
    end

    always_comb begin
        head_any = '0;
        for (int t = 0; t < THREADS; t++) head_any = head_any | head[t];
    end

    assign eligible = head_any & ready & ~kill;

    gct_oldest #(.N(ENTRIES)) u_retire (
        .older (older),
        .cand  (eligible),
        .pick  (commit_oh)
    );

    // ---------------- entry state machines ----------------
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        ent_state_e       st_q, st_d;
        logic [TID_W-1:0] tid_q;
        logic [SLOTS-1:0] vm_q, dm_q, dm_d, hit;

        assign live[e]    = (st_q != ENT_FREE);
        assign ready[e]   = (st_q == ENT_DONE);
        assign tid_all[e] = tid_q;
        assign vm_all[e]  = vm_q;
        assign kill[e]    = flush_valid && (st_q != ENT_FREE) && (tid_q == flush_tid);

        always_comb begin
            hit  = (comp_valid && comp_tag == TAG_W'(e)) ? (SLOTS'(1) << comp_slot) : '0;
            st_d = st_q;
            dm_d = dm_q;
            unique case (st_q)
                ENT_FREE: begin
                    if (alloc_oh[e]) begin
                        st_d = ENT_PEND;
                        dm_d = '0;
                    end
                end
                ENT_PEND: begin
                    if (kill[e]) begin
                        st_d = ENT_FREE;
                    end else begin
                        dm_d = dm_q | (hit & vm_q);
                        if (dm_d == vm_q) st_d = ENT_DONE;
                    end
                end
                ENT_DONE: begin
                    if (kill[e] || commit_oh[e]) st_d = ENT_FREE;
                end
                default: st_d = ENT_FREE;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q  <= ENT_FREE;
                dm_q  <= '0;
                tid_q <= '0;
                vm_q  <= '0;
            end else begin
                st_q <= st_d;
                dm_q <= dm_d;
                if (alloc_oh[e]) begin
                    tid_q <= disp_tid;
                    vm_q  <= disp_mask;
                end
            end
        end
    end

    // ---------------- commit outputs ----------------
    always_comb begin
        commit_valid = |commit_oh;
        commit_tag   = '0;
        commit_tid   = '0;
        commit_mask  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (commit_oh[i]) begin
                commit_tag  = TAG_W'(i);
                commit_tid  = tid_all[i];
                commit_mask = vm_all[i];
            end
        end
    end
endmodule

// File: rtl/gct_table_chk.sv
module gct_table_chk #(
    parameter int ENTRIES = 20,
    parameter int SLOTS   = 5,
    parameter int THREADS = 2,
    localparam int TAG_W  = $clog2(ENTRIES),
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     disp_valid,
    input logic [TID_W-1:0]         disp_tid,
    input logic [SLOTS-1:0]         disp_mask,
    input logic                     disp_stall,
    input logic                     flush_valid,
    input logic [TID_W-1:0]         flush_tid,
    input logic                     commit_valid,
    input logic [TID_W-1:0]         commit_tid,
    input logic [SLOTS-1:0]         commit_mask,
    input logic [THREADS*CNT_W-1:0] occupancy
);
    logic [CNT_W-1:0] occ_t [THREADS];
    logic [CNT_W:0]   total;

    for (genvar t = 0; t < THREADS; t++) begin : g_occ
        assign occ_t[t] = occupancy[t*CNT_W +: CNT_W];
    end

    always_comb begin
        total = '0;
        for (int t = 0; t < THREADS; t++) total = total + (CNT_W+1)'(occ_t[t]);
    end

    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        disp_stall == (total == (CNT_W+1)'(ENTRIES)));  // R4

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        total <= (CNT_W+1)'(ENTRIES));  // R10

    AST_ZERO_MASK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_mask == '0 && !commit_valid && !flush_valid)
        |=> $stable(occupancy));  // R3

    AST_DISP_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_mask != '0 && !disp_stall && !flush_valid && !commit_valid)
        |=> occ_t[$past(disp_tid)] == $past(occ_t[disp_tid]) + CNT_W'(1));  // R2

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> occ_t[$past(flush_tid)] == '0);  // R9

    AST_COMMIT_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !flush_valid && !(disp_valid && disp_tid == commit_tid))
        |=> occ_t[$past(commit_tid)] == $past(occ_t[commit_tid]) - CNT_W'(1));  // R8

    AST_COMMIT_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> commit_mask != '0);  // R3
endmodule

bind gct_table gct_table_chk #(
    .ENTRIES (ENTRIES),
    .SLOTS   (SLOTS),
    .THREADS (THREADS)
) u_chk (.*);

// File: tb/sim_gct_table.sv
module sim_gct_table;
    localparam int N = 20;
    localparam int S = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_valid, disp_tid, disp_stall;
    logic [4:0] disp_mask, disp_tag;
    logic       comp_valid;
    logic [4:0] comp_tag;
    logic [2:0] comp_slot;
    logic       flush_valid, flush_tid;
    logic       commit_valid, commit_tid;
    logic [4:0] commit_tag, commit_mask;
    logic [9:0] occupancy;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gct_table u0 (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_tid(disp_tid), .disp_mask(disp_mask),
        .disp_stall(disp_stall), .disp_tag(disp_tag),
        .comp_valid(comp_valid), .comp_tag(comp_tag), .comp_slot(comp_slot),
        .flush_valid(flush_valid), .flush_tid(flush_tid),
        .commit_valid(commit_valid), .commit_tag(commit_tag),
        .commit_tid(commit_tid), .commit_mask(commit_mask),
        .occupancy(occupancy)
    );

    function automatic logic [4:0] grp_mask(input int i);
        return 5'((i % 31) + 1);
    endfunction

    function automatic int occ(input int t);
        return int'(occupancy[t*5 +: 5]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        disp_valid  = 1'b0;
        comp_valid  = 1'b0;
        flush_valid = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic complete(input int tag, input int slot);
        comp_valid = 1'b1;
        comp_tag   = 5'(tag);
        comp_slot  = 3'(slot);
        step();
        comp_valid = 1'b0;
    endtask

    task automatic dispatch(input int tid, input logic [4:0] m, input int exp_tag, input string req);
        disp_valid = 1'b1;
        disp_tid   = tid[0];
        disp_mask  = m;
        #1;
        chk(req, int'(disp_tag), exp_tag);
        step();
        disp_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle();
        disp_tid = 1'b0; disp_mask = '0; comp_tag = '0; comp_slot = '0; flush_tid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 occ0", occ(0), 0);
        chk("R1 occ1", occ(1), 0);
        chk("R1 stall", int'(disp_stall), 0);
        chk("R1 commit", int'(commit_valid), 0);

        // R3 zero mask ignored
        disp_valid = 1'b1; disp_tid = 1'b0; disp_mask = '0;
        step(); idle();
        chk("R3 occ0", occ(0), 0);
        chk("R3 occ1", occ(1), 0);

        // R2 fill every entry, alternating threads
        for (int i = 0; i < N; i++) begin
            chk("R4 not full", int'(disp_stall), 0);
            dispatch(i % 2, grp_mask(i), i, "R2 tag");
        end
        chk("R10 occ0", occ(0), N / 2);
        chk("R10 occ1", occ(1), N / 2);
        chk("R4 stall", int'(disp_stall), 1);

        // R4 dispatch while full is ignored
        disp_valid = 1'b1; disp_tid = 1'b0; disp_mask = 5'h1F;
        step(); idle();
        chk("R4 occ0 unchanged", occ(0), N / 2);
        chk("R4 occ1 unchanged", occ(1), N / 2);

        // R6 finish groups youngest first: nothing may retire
        for (int t = N - 1; t >= 2; t--) begin
            for (int s = 0; s < S; s++) begin
                if (grp_mask(t)[s]) begin
                    complete(t, s);
                    chk("R6 no commit", int'(commit_valid), 0);
                end
            end
        end

        // R7/R8 thread-1 head finishes first, then thread-0 head
        comp_valid = 1'b1; comp_tag = 5'd1; comp_slot = 3'd1;
        step();
        comp_tag = 5'd0; comp_slot = 3'd0;
        #1;
        chk("R8 commit valid", int'(commit_valid), 1);
        chk("R8 commit tag", int'(commit_tag), 1);
        chk("R8 commit tid", int'(commit_tid), 1);
        chk("R8 commit mask", int'(commit_mask), int'(grp_mask(1)));
        step(); idle();
        chk("R7 older first tag", int'(commit_tag), 0);
        chk("R7 older first tid", int'(commit_tid), 0);
        for (int k = 2; k < N; k++) begin
            step();
            chk("R7 order valid", int'(commit_valid), 1);
            chk("R7 order tag", int'(commit_tag), k);
            chk("R8 order tid", int'(commit_tid), k % 2);
            chk("R8 order mask", int'(commit_mask), int'(grp_mask(k)));
        end
        step();
        chk("R8 drained commit", int'(commit_valid), 0);
        chk("R8 drained occ0", occ(0), 0);
        chk("R8 drained occ1", occ(1), 0);

        // R5 stray and repeated completions
        dispatch(0, 5'b00011, 0, "R2 reuse tag");
        complete(0, 4);
        chk("R5 outside mask", int'(commit_valid), 0);
        complete(7, 0);
        chk("R5 free entry occ0", occ(0), 1);
        chk("R5 free entry occ1", occ(1), 0);
        complete(0, 0);
        chk("R5 partial", int'(commit_valid), 0);
        complete(0, 0);
        chk("R5 repeat", int'(commit_valid), 0);
        complete(0, 1);
        chk("R5 ready", int'(commit_valid), 1);
        chk("R5 ready tag", int'(commit_tag), 0);
        step();
        chk("R5 freed", occ(0), 0);

        // R9 flush one thread
        for (int i = 0; i < 5; i++) dispatch(i % 2, 5'b00001, i, "R2 small tag");
        complete(1, 0);
        chk("R9 pre-flush commit", int'(commit_valid), 1);
        flush_valid = 1'b1; flush_tid = 1'b1;
        disp_valid = 1'b1; disp_tid = 1'b1; disp_mask = 5'b00001;
        #1;
        chk("R9 commit suppressed", int'(commit_valid), 0);
        step(); idle();
        chk("R9 flushed occ1", occ(1), 0);
        chk("R9 other occ0", occ(0), 3);
        dispatch(1, 5'b00001, 1, "R9 refill tag");
        chk("R10 occ1", occ(1), 1);
        flush_valid = 1'b1; flush_tid = 1'b0;
        step(); idle();
        chk("R9 flushed occ0", occ(0), 0);
        chk("R9 kept occ1", occ(1), 1);
        complete(1, 0);
        chk("R9 survivor commits", int'(commit_valid), 1);
        chk("R9 survivor tid", int'(commit_tid), 1);
        step();
        chk("R9 final occ1", occ(1), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule